// File: doc/BRIEF.md
# Debug Command Byte Receiver

This block sits behind the debug data shift register of an on-chip debug engine. The host moves one byte at a time into the engine. The block frames those bytes into complete debug commands. The first byte of each operation is a command byte. Its low nibble selects the operation, and that choice fixes how many follow-on bytes must come next. Follow-on bytes are stored into numbered argument slots in the order they arrive. There is no timeout: the block waits as long as it takes for the last byte.

When a command that needs the utility ROM has all of its bytes, the block does four things:
- publishes the 4-bit operation code;
- sets a sticky ROM enable;
- pulses a jump request towards the fixed service vector 0x8010;
- reports busy.

Single step and return to background are carried out by the block itself, without the ROM.

A two-bit status tells the host what the engine is doing:

| Status | Meaning |
|--------|---------|
| 00 | not in debug |
| 01 | ready |
| 10 | busy |
| 11 | framing lost |

Once framing is lost, the only way out is to move the instruction register away from the debug instruction and load it again.

The states and their transitions are:
- OFF goes to IDLE when the debug instruction is selected.
- IDLE takes a command byte. It then goes to COLLECT if follow-on bytes are due, or to BUSY, STEP, PARKED or LOST for a zero-count ROM operation, a step, a return or an unknown code.
- COLLECT goes to BUSY on the last follow-on byte.
- BUSY goes to IDLE on the ROM done input, or to LOST on any byte.
- STEP goes to IDLE when the stepped instruction retires, or to LOST on any byte.
- PARKED and LOST hold until the debug instruction is deselected.
- Deselecting the debug instruction sends every state to OFF.

Top module: `dbg_cmd_rx`

## Requirements

- R1: After reset the block reports the following, and all arguments are zero:
  - status 00;
  - CPU halt low;
  - ROM enable low;
  - no jump request;
  - operation code 0.
- R2: One clock after the debug instruction is seen as selected while the block is in OFF, status reads 01 and the CPU halt is high.
- R3: The operation is byte bits [3:0], and bits [7:4] are ignored. The codes and their follow-on byte counts are:

  | Code | Operation | Follow-on bytes |
  |------|-----------|-----------------|
  | 0 | register map | 0 |
  | 1 | stack read | 0 |
  | 2 | register read | 1 |
  | 3 | register write | 3 |
  | 4 | memory read | 2 |
  | 5 | memory write | 4 |
  | 6 | single step | 0 |
  | 7 | return | 0 |
  | 8 | unlock | 0 |

- R4: Follow-on byte k (counting from 0) is stored in arg_bytes[8k+7:8k]. All slots clear when a command byte is accepted.
- R5: A ROM-assisted command completes in the cycle after its last required byte, with any number of idle cycles between bytes. At completion:
  - status goes to 10;
  - cmd_code takes the operation;
  - rom_en goes high and stays high until reset;
  - vec_jump is high for exactly one cycle, while vec_addr reads 0x8010.
- R6: rom_done while busy returns status to 01 and clears the byte count. rom_done in any other state has no effect.
- R7: A single step drops the CPU halt with status 10 and no jump request. The halt stays low until step_retired, after which halt is high and status is 01.
- R8: A return pulses resume for one cycle and drops the halt with status 00. Further bytes are ignored until the debug instruction is reselected.
- R9: Either of the following causes framing loss:
  - any byte received while busy or stepping;
  - a command byte with an undefined code 9 to 15.

  Framing loss gives status 11 with the halt held. Later bytes and rom_done leave it there.
- R10: Deselecting the debug instruction gives status 00 and halt low one cycle later. Reselecting it returns the block to ready (01).

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_sel | input | 1 | Debug instruction loaded in the instruction register |
| byte_vld | input | 1 | One-cycle strobe: a host byte is complete |
| byte_in | input | 8 | Host byte |
| rom_done | input | 1 | ROM service routine has finished |
| step_retired | input | 1 | Stepped instruction has retired |
| status | output | 2 | 00 off, 01 ready, 10 busy, 11 framing lost |
| cmd_code | output | 4 | Operation code for the ROM routine |
| rom_en | output | 1 | Sticky utility ROM enable |
| vec_jump | output | 1 | One-cycle forced jump request |
| vec_addr | output | 16 | Service vector address (0x8010) |
| cpu_halt | output | 1 | Holds the CPU stopped |
| resume | output | 1 | One-cycle return-to-background pulse |
| arg_bytes | output | 32 | Follow-on argument slots |

## Verification

The assertions take three things for granted about the inputs:
- rom_done and step_retired are single-cycle strobes;
- byte_vld never stays high across two bytes meant as one;
- dbg_sel changes only between whole transactions, not against a pending strobe.

The stimulus drives every input on the falling edge and holds each strobe for exactly one clock. It raises rom_done only when a completion is expected or when it is meant to be ignored, and raises step_retired only during a step. This keeps each framing-loss case the result of a deliberate stray byte or a bad code.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_COLLECT,
        ST_BUSY,
        ST_STEP,
        ST_PARKED,
        ST_LOST
    } dbg_state_e;

    localparam logic [1:0] STS_NONE  = 2'b00;
    localparam logic [1:0] STS_READY = 2'b01;
    localparam logic [1:0] STS_BUSY  = 2'b10;
    localparam logic [1:0] STS_LOST  = 2'b11;

    localparam logic [3:0] OP_RD_MAP   = 4'd0;
    localparam logic [3:0] OP_RD_STACK = 4'd1;
    localparam logic [3:0] OP_RD_REG   = 4'd2;
    localparam logic [3:0] OP_WR_REG   = 4'd3;
    localparam logic [3:0] OP_RD_MEM   = 4'd4;
    localparam logic [3:0] OP_WR_MEM   = 4'd5;
    localparam logic [3:0] OP_STEP     = 4'd6;
    localparam logic [3:0] OP_RETURN   = 4'd7;
    localparam logic [3:0] OP_UNLOCK   = 4'd8;

    typedef struct packed {
        logic       known;
        logic       rom;
        logic       step;
        logic       ret;
        logic [2:0] follow;
    } op_info_t;

endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
    import dbgcmd_pkg::*;
(
    input  logic [3:0] code,
    output op_info_t   info
);

    always_comb begin
        info = '0;
        unique case (code)
            OP_RD_MAP:   info = '{known: 1'b1, rom: 1'b1, step: 1'b0, ret: 1'b0, follow: 3'd0};
            OP_RD_STACK: info = '{known: 1'b1, rom: 1'b1, step: 1'b0, ret: 1'b0, follow: 3'd0};
            OP_RD_REG:   info = '{known: 1'b1, rom: 1'b1, step: 1'b0, ret: 1'b0, follow: 3'd1};
            OP_WR_REG:   info = '{known: 1'b1, rom: 1'b1, step: 1'b0, ret: 1'b0, follow: 3'd3};
            OP_RD_MEM:   info = '{known: 1'b1, rom: 1'b1, step: 1'b0, ret: 1'b0, follow: 3'd2};
            OP_WR_MEM:   info = '{known: 1'b1, rom: 1'b1, step: 1'b0, ret: 1'b0, follow: 3'd4};
            OP_STEP:     info = '{known: 1'b1, rom: 1'b0, step: 1'b1, ret: 1'b0, follow: 3'd0};
            OP_RETURN:   info = '{known: 1'b1, rom: 1'b0, step: 1'b0, ret: 1'b1, follow: 3'd0};
            OP_UNLOCK:   info = '{known: 1'b1, rom: 1'b1, step: 1'b0, ret: 1'b0, follow: 3'd0};
            default:     info = '0;
        endcase
    end

endmodule

// File: rtl/dbg_arg_store.sv
module dbg_arg_store #(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [IDX_W-1:0]        idx,
    input  logic [BYTE_W-1:0]       din,
    output logic [SLOTS*BYTE_W-1:0] args
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (clr) begin
                slot_q <= '0;
            end else if (wr && (idx == IDX_W'(s))) begin
                slot_q <= din;
            end
        end

        assign args[s*BYTE_W +: BYTE_W] = slot_q;
    end

endmodule

// File: rtl/dbg_cmd_rx.sv
module dbg_cmd_rx
    import dbgcmd_pkg::*;
#(
    parameter int          ARG_BYTES = 4,
    parameter int          BYTE_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] SVC_VEC   = 16'h8010
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dbg_sel,
    input  logic                        byte_vld,
    input  logic [BYTE_W-1:0]           byte_in,
    input  logic                        rom_done,
    input  logic                        step_retired,
    output logic [1:0]                  status,
    output logic [3:0]                  cmd_code,
    output logic                        rom_en,
    output logic                        vec_jump,
    output logic [ADDR_W-1:0]           vec_addr,
    output logic                        cpu_halt,
    output logic                        resume,
    output logic [ARG_BYTES*BYTE_W-1:0] arg_bytes
);

    localparam int CNT_W = $clog2(ARG_BYTES + 1);
    localparam int IDX_W = (ARG_BYTES > 1) ? $clog2(ARG_BYTES) : 1;

    dbg_state_e       state_q, state_d;
    op_info_t         info;
    logic [3:0]       op_q;
    logic [3:0]       cmd_q;
    logic [CNT_W-1:0] idx_q, need_q;
    logic             rom_en_q, jump_q, resume_q;
    logic             take_cmd, take_arg, go_busy, go_ret;

    dbg_op_decode u_dec (
        .code (byte_in[3:0]),
        .info (info)
    );

    dbg_arg_store #(.SLOTS(ARG_BYTES), .BYTE_W(BYTE_W)) u_args (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take_cmd),
        .wr    (take_arg),
        .idx   (idx_q[IDX_W-1:0]),
        .din   (byte_in),
        .args  (arg_bytes)
    );

    // next-state and transition strobes
    always_comb begin
        state_d  = state_q;
        take_cmd = 1'b0;
        take_arg = 1'b0;
        go_busy  = 1'b0;
        go_ret   = 1'b0;
        if (!dbg_sel) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_IDLE;
                ST_IDLE: begin
                    if (byte_vld) begin
                        take_cmd = 1'b1;
                        if (!info.known) begin
                            state_d = ST_LOST;
                        end else if (info.follow != 3'd0) begin
                            state_d = ST_COLLECT;
                        end else if (info.step) begin
                            state_d = ST_STEP;
                        end else if (info.ret) begin
                            state_d = ST_PARKED;
                            go_ret  = 1'b1;
                        end else begin
                            state_d = ST_BUSY;
                            go_busy = 1'b1;
                        end
                    end
                end
                ST_COLLECT: begin
                    if (byte_vld) begin
                        take_arg = 1'b1;
                        if (CNT_W'(idx_q + 1'b1) == need_q) begin
                            state_d = ST_BUSY;
                            go_busy = 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (byte_vld)      state_d = ST_LOST;
                    else if (rom_done) state_d = ST_IDLE;
                end
                ST_STEP: begin
                    if (byte_vld)          state_d = ST_LOST;
                    else if (step_retired) state_d = ST_IDLE;
                end
                ST_PARKED: state_d = ST_PARKED;
                ST_LOST:   state_d = ST_LOST;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // state register and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            op_q     <= '0;
            cmd_q    <= '0;
            idx_q    <= '0;
            need_q   <= '0;
            rom_en_q <= 1'b0;
            jump_q   <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            jump_q   <= go_busy;
            resume_q <= go_ret;
            if (go_busy) rom_en_q <= 1'b1;
            if (take_cmd) begin
                op_q   <= byte_in[3:0];
                idx_q  <= '0;
                need_q <= CNT_W'(info.follow);
            end else if (take_arg) begin
                idx_q <= CNT_W'(idx_q + 1'b1);
            end else if (state_q == ST_BUSY && rom_done) begin
                idx_q <= '0;
            end
            if (go_busy) cmd_q <= take_cmd ? byte_in[3:0] : op_q;
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_COLLECT: begin status = STS_READY; cpu_halt = 1'b1; end
            ST_BUSY:             begin status = STS_BUSY;  cpu_halt = 1'b1; end
            ST_STEP:             begin status = STS_BUSY;  cpu_halt = 1'b0; end
            ST_LOST:             begin status = STS_LOST;  cpu_halt = 1'b1; end
            default:             begin status = STS_NONE;  cpu_halt = 1'b0; end
        endcase
    end

    assign cmd_code = cmd_q;
    assign rom_en   = rom_en_q;
    assign vec_jump = jump_q;
    assign resume   = resume_q;
    assign vec_addr = ADDR_W'(SVC_VEC);

endmodule

// File: rtl/dbg_cmd_rx_chk.sv
module dbg_cmd_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_sel,
    input logic [1:0] status,
    input logic       rom_en,
    input logic       vec_jump,
    input logic       cpu_halt,
    input logic       resume
);

    // R5: jump request lasts one cycle
    a_r5_jump_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_jump |=> !vec_jump);

    // R5: jump request comes with busy status and ROM enabled
    a_r5_jump_busy: assert property (@(posedge clk) disable iff (!rst_n)
        vec_jump |-> (status == 2'b10 && rom_en));

    // R5: ROM enable is sticky
    a_r5_rom_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |=> rom_en);

    // R2: ready status always holds the CPU
    a_r2_ready_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01) |-> cpu_halt);

    // R7: a step never raises the jump request
    a_r7_step_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && !cpu_halt) |-> !vec_jump);

    // R8: resume appears with the CPU released and status off
    a_r8_resume_released: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (status == 2'b00 && !cpu_halt));

    // R9: framing loss holds while the debug instruction stays selected
    a_r9_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b11 && dbg_sel) |=> (status == 2'b11));

    // R10: deselect forces off
    a_r10_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_sel |=> (status == 2'b00 && !cpu_halt));

endmodule

bind dbg_cmd_rx dbg_cmd_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_sel  (dbg_sel),
    .status   (status),
    .rom_en   (rom_en),
    .vec_jump (vec_jump),
    .cpu_halt (cpu_halt),
    .resume   (resume)
);

// File: tb/tb_dbg_cmd_rx.sv
module tb_dbg_cmd_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_sel = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        rom_done = 1'b0;
    logic        step_retired = 1'b0;
    logic [1:0]  status;
    logic [3:0]  cmd_code;
    logic        rom_en, vec_jump, cpu_halt, resume;
    logic [15:0] vec_addr;
    logic [31:0] arg_bytes;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dbg_cmd_rx dut (
        .clk(clk), .rst_n(rst_n), .dbg_sel(dbg_sel), .byte_vld(byte_vld),
        .byte_in(byte_in), .rom_done(rom_done), .step_retired(step_retired),
        .status(status), .cmd_code(cmd_code), .rom_en(rom_en),
        .vec_jump(vec_jump), .vec_addr(vec_addr), .cpu_halt(cpu_halt),
        .resume(resume), .arg_bytes(arg_bytes)
    );

    // {op[1:0], byte[7:0], exp_status[1:0], exp_cmd[3:0]}; op 0 byte, 1 rom_done, 2 idle
    localparam logic [15:0] VEC [20] = '{
        {2'd0, 8'h00, 2'b10, 4'd0},
        {2'd1, 8'h00, 2'b01, 4'd0},
        {2'd0, 8'h02, 2'b01, 4'd0},
        {2'd2, 8'h00, 2'b01, 4'd0},
        {2'd0, 8'h55, 2'b10, 4'd2},
        {2'd1, 8'h00, 2'b01, 4'd2},
        {2'd0, 8'hF4, 2'b01, 4'd2},
        {2'd0, 8'h11, 2'b01, 4'd2},
        {2'd0, 8'h22, 2'b10, 4'd4},
        {2'd1, 8'h00, 2'b01, 4'd4},
        {2'd0, 8'h03, 2'b01, 4'd4},
        {2'd0, 8'h31, 2'b01, 4'd4},
        {2'd0, 8'h32, 2'b01, 4'd4},
        {2'd0, 8'h33, 2'b10, 4'd3},
        {2'd1, 8'h00, 2'b01, 4'd3},
        {2'd1, 8'h00, 2'b01, 4'd3},
        {2'd0, 8'h01, 2'b10, 4'd1},
        {2'd1, 8'h00, 2'b01, 4'd1},
        {2'd0, 8'h08, 2'b10, 4'd8},
        {2'd1, 8'h00, 2'b01, 4'd8}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive for one clock from a falling edge; return at the next falling edge
    task automatic step_op(input logic [1:0] op, input logic [7:0] b);
        @(negedge clk);
        byte_vld = (op == 2'd0);
        byte_in  = b;
        rom_done = (op == 2'd1);
        @(negedge clk);
        byte_vld = 1'b0;
        rom_done = 1'b0;
    endtask

    task automatic set_sel(input logic v);
        @(negedge clk);
        dbg_sel = v;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status == 2'b00 && !cpu_halt, "R1 status/halt", {30'd0, status}, 32'h0);
        check(!rom_en && !vec_jump && cmd_code == 4'd0 && arg_bytes == 32'd0,
              "R1 rom_en/jump/cmd/args", {27'd0, rom_en, vec_jump, cmd_code}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        set_sel(1'b1);
        check(status == 2'b01 && cpu_halt, "R2 ready after select", {30'd0, status}, 32'h1);

        // R3 R5 R6 table walk
        for (int i = 0; i < 20; i++) begin
            step_op(VEC[i][15:14], VEC[i][13:6]);
            check(status == VEC[i][5:4], $sformatf("R3/R6 row %0d status", i), {30'd0, status}, {30'd0, VEC[i][5:4]});
            check(cmd_code == VEC[i][3:0], $sformatf("R5 row %0d cmd", i), {28'd0, cmd_code}, {28'd0, VEC[i][3:0]});
        end

        // R4 R5 memory write with four arguments
        step_op(2'd0, 8'h05);
        step_op(2'd0, 8'hA1);
        step_op(2'd0, 8'hB2);
        step_op(2'd2, 8'h00);
        step_op(2'd0, 8'hC3);
        check(status == 2'b01, "R5 no early completion", {30'd0, status}, 32'h1);
        step_op(2'd0, 8'hD4);
        check(arg_bytes == 32'hD4C3B2A1, "R4 slot order", arg_bytes, 32'hD4C3B2A1);
        check(vec_jump && status == 2'b10 && cmd_code == 4'd5, "R5 completion", {27'd0, vec_jump, cmd_code}, 32'h15);
        check(rom_en && vec_addr == 16'h8010, "R5 rom_en/vector", {15'd0, rom_en, vec_addr}, 32'h18010);
        step_op(2'd2, 8'h00);
        check(!vec_jump, "R5 jump one cycle", {31'd0, vec_jump}, 32'h0);
        step_op(2'd1, 8'h00);
        step_op(2'd0, 8'h02);
        check(arg_bytes == 32'd0, "R4 clear on command", arg_bytes, 32'h0);
        step_op(2'd0, 8'h77);
        check(arg_bytes == 32'h00000077, "R4 slot0", arg_bytes, 32'h77);
        step_op(2'd1, 8'h00);

        // R7 single step
        step_op(2'd0, 8'h06);
        check(status == 2'b10 && !cpu_halt && !vec_jump, "R7 step released",
              {29'd0, status, cpu_halt}, 32'h4);
        step_op(2'd2, 8'h00);
        check(!cpu_halt, "R7 waits retire", {31'd0, cpu_halt}, 32'h0);
        @(negedge clk); step_retired = 1'b1;
        @(negedge clk); step_retired = 1'b0;
        check(status == 2'b01 && cpu_halt && cmd_code == 4'd2, "R7 rehalt",
              {27'd0, status, cpu_halt, cmd_code[1:0]}, 32'h0E);

        // R9 byte while busy
        step_op(2'd0, 8'h00);
        step_op(2'd0, 8'h00);
        check(status == 2'b11 && cpu_halt, "R9 byte in busy", {30'd0, status}, 32'h3);
        step_op(2'd1, 8'h00);
        step_op(2'd0, 8'h00);
        check(status == 2'b11, "R9 lost sticky", {30'd0, status}, 32'h3);

        // R10 recovery
        set_sel(1'b0);
        check(status == 2'b00 && !cpu_halt, "R10 deselect", {30'd0, status}, 32'h0);
        set_sel(1'b1);
        check(status == 2'b01, "R10 reselect", {30'd0, status}, 32'h1);

        // R9 undefined code
        step_op(2'd0, 8'h0C);
        check(status == 2'b11, "R9 undefined code", {30'd0, status}, 32'h3);
        set_sel(1'b0);
        set_sel(1'b1);

        // R8 return
        step_op(2'd0, 8'h07);
        check(resume && status == 2'b00 && !cpu_halt, "R8 return", {29'd0, resume, status}, 32'h4);
        step_op(2'd0, 8'h00);
        check(!resume && status == 2'b00 && cmd_code == 4'd0, "R8 bytes ignored",
              {29'd0, resume, status}, 32'h0);
        check(rom_en, "R5 rom_en sticky", {31'd0, rom_en}, 32'h1);
        set_sel(1'b0);
        set_sel(1'b1);
        check(status == 2'b01 && cpu_halt, "R10 back to ready", {30'd0, status}, 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule